// File: doc/BRIEF.md
# Programmable Threshold Alert Comparator

This block watches the stream of signed conversion results leaving an analog-to-digital converter and decides when to raise an alert pin. Every result that arrives with its valid strobe is compared digitally against a programmable low limit and a programmable high limit. There are two ways to judge a result. In hysteresis style the alert comes on above the high limit and goes off only below the low limit. In window style any result outside the band between the two limits counts.

A run-length filter suppresses isolated excursions: the alert is raised only after 1, 2 or 4 out-of-limit results in a row, as chosen by a two-bit code. The fourth code turns the comparator off and releases the pin (output-enable low). The pin level can be active high or active low. The alert can also be made sticky, so that it holds until the host reads the result, which is signalled by a clear strobe. Writing a limit or changing the run-length code restarts the run count.

Top module: `thr_alert`

## Requirements
- R1: After reset, `alert_oe` is 0 and the internal alert state is inactive, so `alert_o` shows the inactive level for the selected polarity.
- R2: A result counts as above the high limit only when it is strictly greater, and as below the low limit only when it is strictly smaller. All comparisons use two's-complement signed values of DATA_W bits, from -2048 to 2047 at the default width.
- R3: With `cfg_window`=1, a result that is above the high limit or below the low limit is out of limit. In non-sticky mode, a valid result inside the band (lo <= x <= hi) drops the alert at the same clock edge.
- R4: With `cfg_window`=0, only a result above the high limit is out of limit. Once raised, a non-sticky alert stays on for results between the limits and drops on a valid result below the low limit.
- R5: `cfg_queue` codes 0, 1 and 2 raise the alert on the 1st, 2nd and 4th consecutive out-of-limit valid result. Any valid result that is not out of limit sets the run count back to zero.
- R6: `cfg_queue`=3 turns the comparator off. From the next edge `alert_oe` is 0, the alert state is inactive, the run count is zero and results are ignored. Any other code drives `alert_oe` to 1 from the next edge.
- R7: `cfg_act_high`=1 drives `alert_o`=1 while the alert is active. `cfg_act_high`=0 drives `alert_o`=0 while the alert is active. The inactive level is the opposite in each case, and it follows the polarity bit without delay.
- R8: With `cfg_latch`=1, an active alert stays on whatever later results show, until a cycle with `rd_clr`=1 clears it at that edge. A result that raises the alert in the same cycle takes priority over the clear.
- R9: With `cfg_latch`=0, `rd_clr` has no effect on the alert.
- R10: In a cycle where `thr_wr`=1, or where `cfg_queue` differs from its value in the previous cycle, the run count is set to zero and that cycle's result is ignored.
- R11: A result sampled at a rising edge affects `alert_o` only after that edge, never before it.
- R12: A cycle with `res_valid`=0 changes neither the run count nor the alert state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | A new conversion result is present |
| res_data | input | DATA_W | Signed conversion result |
| thr_lo | input | DATA_W | Signed low limit |
| thr_hi | input | DATA_W | Signed high limit |
| thr_wr | input | 1 | A limit register is written this cycle |
| cfg_window | input | 1 | 1 = window style, 0 = hysteresis style |
| cfg_act_high | input | 1 | 1 = active-high alert pin, 0 = active-low |
| cfg_latch | input | 1 | 1 = sticky alert |
| cfg_queue | input | 2 | Run length code: 0/1/2 = 1/2/4 results, 3 = off |
| rd_clr | input | 1 | Result read; clears a sticky alert |
| alert_o | output | 1 | Alert pin level |
| alert_oe | output | 1 | Alert pin output enable |

## Verification
The bench builds the block with DATA_W at its default of 12 and MAX_RUN at 4. At this size the extreme codes -2048 and 2047 can be driven directly, including a high limit of 2047, whose "limit plus one" stimulus wraps to -2048. The bench sweeps every combination of style, polarity, stickiness and run-length code against three limit pairs: a normal band, equal limits and the full range. Each sweep uses a result pattern that hits the limits, their neighbours and both extremes, with idle cycles and read strobes mixed in. A directed sequence first pins down the edge timing, the run-count restarts and the polarity levels with literal values.

// File: rtl/thr_alert_pkg.sv
package thr_alert_pkg;

  // Width of the run-length selector and the code that switches the comparator off.
  localparam int QCODE_W = 2;
  localparam logic [QCODE_W-1:0] QCODE_OFF = 2'd3;

  // Longest run the filter may demand; sets the counter width.
  localparam int MAX_RUN = 4;
  localparam int RUN_W   = $clog2(MAX_RUN + 1);

  // Consecutive out-of-limit results needed for a given selector code.
  function automatic logic [RUN_W-1:0] run_needed(input logic [QCODE_W-1:0] code);
    return RUN_W'(1) << code;
  endfunction

endpackage

// File: rtl/thr_alert_cmp.sv
module thr_alert_cmp #(
  parameter int DATA_W = 12
) (
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [DATA_W-1:0] lim_lo,
  input  logic signed [DATA_W-1:0] lim_hi,
  input  logic                     window,
  output logic                     out_of_lim,
  output logic                     releases
);

  logic over_hi;
  logic under_lo;

  always_comb begin
    over_hi    = sample > lim_hi;
    under_lo   = sample < lim_lo;
    out_of_lim = window ? (over_hi || under_lo) : over_hi;
    // Window style drops inside the band; hysteresis style only below the low limit.
    releases   = window ? !(over_hi || under_lo) : under_lo;
  end

endmodule

// File: rtl/thr_alert_queue.sv
module thr_alert_queue #(
  parameter  int MAX_RUN = 4,
  localparam int CNT_W   = $clog2(MAX_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             step,
  input  logic             hit_in,
  input  logic [CNT_W-1:0] need,
  output logic [CNT_W-1:0] run,
  output logic             reached
);

  localparam logic [CNT_W-1:0] RUN_CAP = CNT_W'(MAX_RUN);

  logic [CNT_W-1:0] run_inc;

  always_comb begin
    run_inc = (run == RUN_CAP) ? run : run + CNT_W'(1);
    reached = step && hit_in && (run_inc >= need);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      run <= '0;
    else if (flush)  run <= '0;
    else if (step)   run <= hit_in ? run_inc : '0;
  end

  assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_CAP);

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (run == '0));

  assert_miss_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hit_in && !flush) |=> (run == '0));

endmodule

// File: rtl/thr_alert_state.sv
module thr_alert_state (
  input  logic clk,
  input  logic rst_n,
  input  logic off,
  input  logic step,
  input  logic reached,
  input  logic releases,
  input  logic latch,
  input  logic clr,
  input  logic window,
  output logic active,
  output logic oe
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      oe     <= 1'b0;
    end else begin
      oe <= !off;
      if (off)                  active <= 1'b0;
      else if (reached)         active <= 1'b1;
      else if (latch) begin
        if (clr)                active <= 1'b0;
      end else if (step && releases) active <= 1'b0;
    end
  end

  assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (!oe && !active));

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && latch && !clr && !off) |=> active);

  assert_window_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && window && releases && !latch && !reached) |=> !active);

  assert_hyst_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !window && !latch && !off && !(step && releases)) |=> active);

endmodule

// File: rtl/thr_alert.sv
module thr_alert #(
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     res_valid,
  input  logic signed [DATA_W-1:0] res_data,
  input  logic signed [DATA_W-1:0] thr_lo,
  input  logic signed [DATA_W-1:0] thr_hi,
  input  logic                     thr_wr,
  input  logic                     cfg_window,
  input  logic                     cfg_act_high,
  input  logic                     cfg_latch,
  input  logic [1:0]               cfg_queue,
  input  logic                     rd_clr,
  output logic                     alert_o,
  output logic                     alert_oe
);

  import thr_alert_pkg::*;

  logic [QCODE_W-1:0] queue_prev;
  logic               q_off;
  logic               q_changed;
  logic               flush;
  logic               step;
  logic               out_of_lim;
  logic               releases;
  logic [RUN_W-1:0]   need;
  logic [RUN_W-1:0]   run;
  logic               reached;
  logic               active;

  always_comb begin
    q_off     = cfg_queue == QCODE_OFF;
    q_changed = cfg_queue != queue_prev;
    flush     = q_off || q_changed || thr_wr;
    step      = res_valid && !flush;
    need      = run_needed(cfg_queue);
  end

  // The previous code starts at the off code, so the first enabled cycle restarts the count.
  always_ff @(posedge clk) begin
    if (!rst_n) queue_prev <= QCODE_OFF;
    else        queue_prev <= cfg_queue;
  end

  thr_alert_cmp #(.DATA_W(DATA_W)) u_cmp (
    .sample     (res_data),
    .lim_lo     (thr_lo),
    .lim_hi     (thr_hi),
    .window     (cfg_window),
    .out_of_lim (out_of_lim),
    .releases   (releases)
  );

  thr_alert_queue #(.MAX_RUN(MAX_RUN)) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .step    (step),
    .hit_in  (out_of_lim),
    .need    (need),
    .run     (run),
    .reached (reached)
  );

  thr_alert_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .off      (q_off),
    .step     (step),
    .reached  (reached),
    .releases (releases),
    .latch    (cfg_latch),
    .clr      (rd_clr),
    .window   (cfg_window),
    .active   (active),
    .oe       (alert_oe)
  );

  assign alert_o = cfg_act_high ? active : !active;

  assert_idle_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !q_off && !rd_clr) |=> ($stable(active) && (run == '0 || $stable(run))));

endmodule

// File: tb/sim_thr_alert.sv
module sim_thr_alert;

  localparam int DW = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst_n;
  logic                 res_valid;
  logic signed [DW-1:0] res_data;
  logic signed [DW-1:0] thr_lo;
  logic signed [DW-1:0] thr_hi;
  logic                 thr_wr;
  logic                 cfg_window;
  logic                 cfg_act_high;
  logic                 cfg_latch;
  logic [1:0]           cfg_queue;
  logic                 rd_clr;
  logic                 alert_o;
  logic                 alert_oe;

  thr_alert #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .thr_wr(thr_wr), .cfg_window(cfg_window),
    .cfg_act_high(cfg_act_high), .cfg_latch(cfg_latch), .cfg_queue(cfg_queue),
    .rd_clr(rd_clr), .alert_o(alert_o), .alert_oe(alert_oe)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Bench-side model of the requirements.
  int         m_cnt;
  logic       m_act;
  logic       m_oe;
  logic [1:0] m_qp;

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_act = 1'b0; m_oe = 1'b0; m_qp = 2'd3;
  endtask

  task automatic model_edge();
    logic ex;
    logic rel;
    logic set;
    logic live;
    int   need;
    need = 1 << cfg_queue;
    set  = 1'b0;
    rel  = 1'b0;
    if (cfg_queue == 2'd3) begin
      m_cnt = 0; m_act = 1'b0; m_oe = 1'b0;
    end else begin
      m_oe = 1'b1;
      live = !(cfg_queue != m_qp || thr_wr);
      if (!live) m_cnt = 0;
      else if (res_valid) begin
        ex  = cfg_window ? (res_data > thr_hi || res_data < thr_lo) : (res_data > thr_hi);
        rel = cfg_window ? !ex : (res_data < thr_lo);
        if (ex) begin
          if (m_cnt < 4) m_cnt++;
          set = m_cnt >= need;
        end else m_cnt = 0;
      end
      if (set) m_act = 1'b1;
      else if (cfg_latch) begin
        if (rd_clr) m_act = 1'b0;
      end else if (rel) m_act = 1'b0;
    end
    m_qp = cfg_queue;
  endtask

  task automatic cyc(input logic v, input logic signed [DW-1:0] d, input logic c, input logic w);
    @(negedge clk);
    res_valid = v; res_data = d; rd_clr = c; thr_wr = w;
    @(posedge clk);
    #1;
    model_edge();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; res_valid = 1'b0; rd_clr = 1'b0; thr_wr = 1'b0; res_data = '0;
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  function automatic logic signed [DW-1:0] pick(input int i, input logic signed [DW-1:0] lo,
                                                 input logic signed [DW-1:0] hi);
    case ((i * 3 + i / 4) % 8)
      0: return hi + 1;
      1: return hi;
      2: return lo;
      3: return lo - 1;
      4: return '0;
      5: return 12'sd2047;
      6: return -12'sd2048;
      default: return hi + 1;
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; res_valid = 1'b0; res_data = '0; thr_wr = 1'b0; rd_clr = 1'b0;
    thr_lo = -12'sd100; thr_hi = 12'sd200;
    cfg_window = 1'b0; cfg_act_high = 1'b1; cfg_latch = 1'b0; cfg_queue = 2'd3;
    do_reset();
    chk("R1 oe", alert_oe, 1'b0);
    chk("R1 pin", alert_o, 1'b0);

    cfg_queue = 2'd0;
    cyc(1'b0, '0, 1'b0, 1'b0);
    chk("R6 enable oe", alert_oe, 1'b1);
    cyc(1'b1, 12'sd200, 1'b0, 1'b0);
    chk("R2 equal hi", alert_o, 1'b0);
    cyc(1'b1, 12'sd201, 1'b0, 1'b0);
    chk("R2 above hi", alert_o, 1'b1);
    cyc(1'b1, -12'sd100, 1'b0, 1'b0);
    chk("R4 hold at lo", alert_o, 1'b1);
    cyc(1'b0, -12'sd2048, 1'b0, 1'b0);
    chk("R12 idle", alert_o, 1'b1);
    cyc(1'b1, -12'sd101, 1'b0, 1'b0);
    chk("R4 drop below lo", alert_o, 1'b0);

    @(negedge clk);
    res_valid = 1'b1; res_data = 12'sd201;
    #1;
    chk("R11 before edge", alert_o, 1'b0);
    @(posedge clk);
    #1;
    chk("R11 after edge", alert_o, 1'b1);
    cyc(1'b1, -12'sd101, 1'b0, 1'b0);
    chk("R4 drop", alert_o, 1'b0);

    cfg_queue = 2'd2;
    cyc(1'b1, 12'sd201, 1'b0, 1'b0);
    chk("R10 code change ignored", alert_o, 1'b0);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 12'sd201, 1'b0, 1'b0);
      chk("R5 run below 4", alert_o, 1'b0);
    end
    cyc(1'b1, 12'sd201, 1'b0, 1'b0);
    chk("R5 fourth run", alert_o, 1'b1);
    cyc(1'b1, -12'sd101, 1'b0, 1'b0);
    cyc(1'b1, 12'sd201, 1'b0, 1'b0);
    cyc(1'b1, 12'sd201, 1'b0, 1'b0);
    cyc(1'b1, 12'sd0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 12'sd201, 1'b0, 1'b0);
      chk("R5 restart after miss", alert_o, 1'b0);
    end
    cyc(1'b1, 12'sd201, 1'b0, 1'b0);
    chk("R5 run complete", alert_o, 1'b1);
    cyc(1'b1, -12'sd101, 1'b0, 1'b0);

    for (int k = 0; k < 3; k++) cyc(1'b1, 12'sd201, 1'b0, 1'b0);
    cyc(1'b1, 12'sd201, 1'b0, 1'b1);
    chk("R10 write ignored", alert_o, 1'b0);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 12'sd201, 1'b0, 1'b0);
      chk("R10 count restarted", alert_o, 1'b0);
    end
    cyc(1'b1, 12'sd201, 1'b0, 1'b0);
    chk("R10 run after write", alert_o, 1'b1);
    cyc(1'b1, -12'sd101, 1'b0, 1'b0);

    cfg_queue = 2'd0;
    cyc(1'b0, '0, 1'b0, 1'b0);
    cyc(1'b1, 12'sd201, 1'b0, 1'b0);
    cyc(1'b0, '0, 1'b1, 1'b0);
    chk("R9 clear ignored", alert_o, 1'b1);
    cyc(1'b1, -12'sd101, 1'b0, 1'b0);

    cfg_act_high = 1'b0;
    #1;
    chk("R7 low inactive", alert_o, 1'b1);
    cyc(1'b1, 12'sd201, 1'b0, 1'b0);
    chk("R7 low active", alert_o, 1'b0);
    cyc(1'b1, -12'sd101, 1'b0, 1'b0);
    cfg_act_high = 1'b1;

    cfg_latch = 1'b1; cfg_window = 1'b1;
    cyc(1'b1, -12'sd500, 1'b0, 1'b0);
    chk("R3 below lo window", alert_o, 1'b1);
    cyc(1'b1, 12'sd0, 1'b0, 1'b0);
    chk("R8 sticky", alert_o, 1'b1);
    cyc(1'b0, '0, 1'b1, 1'b0);
    chk("R8 cleared", alert_o, 1'b0);

    cfg_queue = 2'd3;
    cyc(1'b1, 12'sd201, 1'b0, 1'b0);
    chk("R6 off oe", alert_oe, 1'b0);
    chk("R6 off pin", alert_o, 1'b0);

    for (int t = 0; t < 3; t++) begin
      for (int cfg = 0; cfg < 32; cfg++) begin
        string tag;
        thr_lo = (t == 0) ? -12'sd100 : (t == 1) ? 12'sd0 : -12'sd2048;
        thr_hi = (t == 0) ? 12'sd200  : (t == 1) ? 12'sd0 : 12'sd2047;
        cfg_window   = cfg[0];
        cfg_latch    = cfg[1];
        cfg_act_high = cfg[2];
        cfg_queue    = 2'(cfg >> 3);
        tag = (cfg_queue == 2'd3) ? "R6 sweep" : cfg_latch ? "R8 sweep" :
              cfg_window ? "R3 sweep" : "R4 sweep";
        do_reset();
        for (int i = 0; i < 24; i++) begin
          cyc((i % 6) != 5, pick(i, thr_lo, thr_hi), (i % 5) == 4, i == 17);
          chk(tag, alert_o, cfg_act_high ? m_act : !m_act);
          chk(tag, alert_oe, m_oe);
        end
      end
    end

    finish_run();
  end

endmodule